// File: doc/BRIEF.md
# RS-485 Multidrop Address Filter

This block sits between a 9-bit UART receiver and the receive FIFO. Every received character carries a ninth bit in the parity position. When that bit is 1 the character is an address; when it is 0 the character is data. The block decides, one character at a time, whether the character is written into the FIFO. It also keeps the receiver-enabled state that makes that decision for data characters.

Two multidrop modes can be switched on independently.

- **Flagging mode.** An address character raises an interrupt pulse, the same event a parity error produces. Software then chooses whether to turn the receiver off with the disable control.
- **Automatic mode.** Each address character is compared with an 8-bit station address. A match stores the address and enables the receiver. A mismatch disables the receiver, so the data that follows is dropped until a matching address arrives.

With both modes off, the block is a plain pass-through. All its outputs are registered, and they appear one clock after the input character.

Top module: `rs485_addr_filter`

## Requirements
- R1: A FIFO write happens only in the cycle right after a cycle with `rx_valid` high. The written word holds the received byte in bits [7:0] and the received ninth bit in bit 8.
- R2: With flagging mode on, an address character (ninth bit 1) pulses `addr_irq` for one cycle, one cycle after `rx_valid`. If automatic mode is off, that address is written to the FIFO even while the receiver is disabled.
- R3: A character whose ninth bit is 0 is written only while `rx_enabled` is high in the cycle it arrives. This holds in every mode.
- R4: With automatic mode on, an address character equal to `station_addr` is written with bit 8 = 1, and `rx_enabled` is 1 from the next cycle.
- R5: With automatic mode on, an address character that differs from `station_addr` is not written. `rx_enabled` becomes 0 from the next cycle, and the data characters that follow are discarded.
- R6: A pulse on `rxdis_wr` sets `rx_enabled` to the inverse of `rxdis_val` from the next cycle. It wins over an address character arriving in the same cycle. The value it sets holds until the next address character seen in automatic mode.
- R7: With automatic mode off, `rx_enabled` changes only through `rxdis_wr`.
- R8: After reset, `rx_enabled` is 1 and `fifo_wr` and `addr_irq` are 0. With both modes off, every character is written while the receiver is enabled, and its ninth bit is passed through unchanged.
- R9: `addr_irq` stays low whenever flagging mode is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_bit9 | input | 1 | Ninth bit (address marker) |
| mode_flag | input | 1 | Flagging multidrop mode enable |
| mode_auto | input | 1 | Automatic address detect enable |
| rxdis_wr | input | 1 | Write strobe for the receiver-disable control |
| rxdis_val | input | 1 | Value written to the receiver-disable control (1 = disable) |
| station_addr | input | 8 | Address compared in automatic mode |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 9 | FIFO write word: {ninth bit, byte} |
| addr_irq | output | 1 | Address-seen interrupt pulse |
| rx_enabled | output | 1 | Receiver-enabled status |

## Verification
The assertions check, on every cycle, the local cause-and-effect links:
- writes only follow a valid character;
- data words only pass while the receiver is enabled;
- the interrupt only follows an address character in flagging mode;
- a matching address enables the receiver and a mismatch disables it;
- the enable state holds still outside automatic mode unless software writes it.

Only the bench scenarios can show the longer sequences. These include a mismatch that silences a run of data until a later match, a software disable that persists across many characters, a disable written in the same cycle as a matching address, and an address stored while the receiver is off.

// File: rtl/afil_pkg.sv
// Shared types for the multidrop address filter.
// Assumes an 8-bit character plus one marker bit.
package afil_pkg;
    localparam int CHAR_W = 8;
    localparam int WORD_W = CHAR_W + 1;

    // Classified character handed from the classifier to the other stages
    typedef struct packed {
        logic              valid;    // character present this cycle
        logic              is_addr;  // ninth bit set
        logic              match;    // byte equals station address
        logic [CHAR_W-1:0] data;     // received byte
    } afil_char_t;
endpackage

// File: rtl/afil_classify.sv
// Classifies an incoming character: address or data, and whether the byte
// equals the programmed station address. Purely combinational.
// Assumes rx_valid is a one-cycle strobe per character.
module afil_classify
    import afil_pkg::*;
#(
    parameter int W = CHAR_W
) (
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_bit9,
    input  logic [W-1:0] station_addr,
    output afil_char_t   chr
);
    // Build the classified character record
    always_comb begin
        chr.valid   = rx_valid;
        chr.is_addr = rx_bit9;
        chr.match   = (rx_data == station_addr);
        chr.data    = rx_data;
    end
endmodule

// File: rtl/afil_rxen_ctl.sv
// Receiver-enabled state. A software write has the highest priority. Below
// it, an address character seen in automatic mode sets the state to the
// compare result. Otherwise the state holds.
// Assumes a synchronous active-low reset; the state comes out of reset enabled.
module afil_rxen_ctl
    import afil_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  afil_char_t chr,
    input  logic       mode_auto,
    input  logic       rxdis_wr,
    input  logic       rxdis_val,
    output logic       rx_en
);
    logic rx_en_q;
    logic auto_hit;

    // An address character that the automatic mode acts on
    always_comb auto_hit = mode_auto && chr.valid && chr.is_addr;

    // Update the enable state by priority: software, then auto compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q <= 1'b1;
        end else if (rxdis_wr) begin
            rx_en_q <= !rxdis_val;
        end else if (auto_hit) begin
            rx_en_q <= chr.match;
        end
    end

    assign rx_en = rx_en_q;

    AST_MATCH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_hit && chr.match && !rxdis_wr) |=> rx_en_q) else $error("match"); // R4
    AST_MISMATCH_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_hit && !chr.match && !rxdis_wr) |=> !rx_en_q) else $error("mismatch"); // R5
    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rxdis_wr |=> (rx_en_q == !$past(rxdis_val))) else $error("sw write"); // R6
    AST_HOLD_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_auto && !rxdis_wr) |=> $stable(rx_en_q)) else $error("hold"); // R7
endmodule

// File: rtl/afil_wr_gate.sv
// Decides whether each character is written to the FIFO and raises the
// address interrupt. All outputs are registered, so they appear one cycle
// after the character. Uses the enable state as it stands when the
// character arrives.
// Assumes the classifier output is valid in the same cycle as rx_valid.
module afil_wr_gate
    import afil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  afil_char_t        chr,
    input  logic              mode_flag,
    input  logic              mode_auto,
    input  logic              rx_en,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              addr_irq
);
    logic wr_d;
    logic irq_d;

    // Write decision: auto compare for addresses, flag mode stores
    // addresses, everything else is gated by the enable state
    always_comb begin
        wr_d = 1'b0;
        if (chr.valid) begin
            if (mode_auto && chr.is_addr) begin
                wr_d = chr.match;
            end else if (mode_flag && chr.is_addr) begin
                wr_d = 1'b1;
            end else begin
                wr_d = rx_en;
            end
        end
    end

    // Interrupt decision: address character while flagging mode is on
    always_comb irq_d = chr.valid && chr.is_addr && mode_flag;

    // Register the FIFO write port and the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
            addr_irq  <= 1'b0;
        end else begin
            fifo_wr  <= wr_d;
            addr_irq <= irq_d;
            if (wr_d) begin
                fifo_data <= {chr.is_addr, chr.data};
            end
        end
    end

    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(chr.valid)) else $error("write w/o valid"); // R1
    AST_DATA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !fifo_data[CHAR_W]) |-> $past(rx_en)) else $error("data while off"); // R3
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_irq |-> $past(mode_flag && chr.valid && chr.is_addr)) else $error("irq"); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_flag |=> !addr_irq) else $error("irq w/o flag mode"); // R9
endmodule

// File: rtl/rs485_addr_filter.sv
// Top of the multidrop address filter. Connects the classifier, the
// receiver-enabled state and the FIFO write gate.
// Assumes one character per rx_valid strobe, with the ninth bit aligned
// to the byte.
module rs485_addr_filter
    import afil_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              mode_flag,
    input  logic              mode_auto,
    input  logic              rxdis_wr,
    input  logic              rxdis_val,
    input  logic [CHAR_W-1:0] station_addr,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              addr_irq,
    output logic              rx_enabled
);
    afil_char_t chr;
    logic       rx_en;

    afil_classify #(.W(CHAR_W)) u_cls (
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_bit9      (rx_bit9),
        .station_addr (station_addr),
        .chr          (chr)
    );

    afil_rxen_ctl u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr       (chr),
        .mode_auto (mode_auto),
        .rxdis_wr  (rxdis_wr),
        .rxdis_val (rxdis_val),
        .rx_en     (rx_en)
    );

    afil_wr_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr       (chr),
        .mode_flag (mode_flag),
        .mode_auto (mode_auto),
        .rx_en     (rx_en),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .addr_irq  (addr_irq)
    );

    assign rx_enabled = rx_en;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (rx_enabled && !fifo_wr && !addr_irq)) else $error("reset"); // R8
endmodule

// File: tb/tb_rs485_addr_filter.sv
module tb_rs485_addr_filter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       mode_flag;
    logic       mode_auto;
    logic       rxdis_wr;
    logic       rxdis_val;
    logic [7:0] station_addr;
    logic       fifo_wr;
    logic [8:0] fifo_data;
    logic       addr_irq;
    logic       rx_enabled;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  m_en  = 1'b1;  // bench model of the receiver-enabled state
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_addr_filter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_bit9      (rx_bit9),
        .mode_flag    (mode_flag),
        .mode_auto    (mode_auto),
        .rxdis_wr     (rxdis_wr),
        .rxdis_val    (rxdis_val),
        .station_addr (station_addr),
        .fifo_wr      (fifo_wr),
        .fifo_data    (fifo_data),
        .addr_irq     (addr_irq),
        .rx_enabled   (rx_enabled)
    );

    // Expected write strobe from the requirements (R2, R3, R4, R5, R8)
    function automatic bit exp_write(bit v, bit b9, bit [7:0] d, bit [7:0] sa,
                                     bit fl, bit au, bit en);
        if (!v) return 1'b0;
        if (au && b9) return d == sa;
        if (fl && b9) return 1'b1;
        return en;
    endfunction

    // Expected next enable state (R4, R5, R6, R7)
    function automatic bit exp_en(bit v, bit b9, bit [7:0] d, bit [7:0] sa,
                                  bit au, bit sw, bit swv, bit en);
        if (sw) return !swv;
        if (au && v && b9) return d == sa;
        return en;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, then compare against the model
    task automatic step(bit v, bit b9, bit [7:0] d, bit sw, bit swv, string tag);
        bit       e_wr;
        bit       e_irq;
        bit       e_en;
        bit [8:0] e_word;
        rx_valid  = v;
        rx_bit9   = b9;
        rx_data   = d;
        rxdis_wr  = sw;
        rxdis_val = swv;
        e_wr   = exp_write(v, b9, d, station_addr, mode_flag, mode_auto, m_en);
        e_irq  = v && b9 && mode_flag;
        e_en   = exp_en(v, b9, d, station_addr, mode_auto, sw, swv, m_en);
        e_word = {b9, d};
        @(posedge clk);
        #2;
        chk({tag, " R1 fifo_wr"}, int'(fifo_wr), int'(e_wr));
        if (e_wr) chk({tag, " R1 fifo_data"}, int'(fifo_data), int'(e_word));
        chk({tag, " R2/R9 addr_irq"}, int'(addr_irq), int'(e_irq));
        chk({tag, " R6 rx_enabled"}, int'(rx_enabled), int'(e_en));
        m_en = e_en;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0; rx_valid = 0; rx_data = 0; rx_bit9 = 0;
        mode_flag = 0; mode_auto = 0; rxdis_wr = 0; rxdis_val = 0;
        station_addr = 8'h5A;
        repeat (3) @(posedge clk);
        #2;
        // R8: reset state
        chk("R8 reset rx_enabled", int'(rx_enabled), 1);
        chk("R8 reset fifo_wr", int'(fifo_wr), 0);
        chk("R8 reset addr_irq", int'(addr_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m_en  = 1'b1;

        // R8: pass-through, ninth bit kept
        step(1, 1, 8'h11, 0, 0, "R8 pass addr-bit");
        step(1, 0, 8'h22, 0, 0, "R8 pass data");
        // R3: software disable drops data outside multidrop modes
        step(0, 0, 8'h00, 1, 1, "R6 sw disable");
        step(1, 0, 8'h33, 0, 0, "R3 data dropped");

        // R2: flagging mode stores an address even while disabled
        mode_flag = 1;
        step(1, 1, 8'h44, 0, 0, "R2 addr while off");
        step(1, 0, 8'h45, 0, 0, "R3 data off flag");
        step(0, 0, 8'h00, 1, 0, "R6 sw enable");
        step(1, 0, 8'h46, 0, 0, "R3 data on flag");
        mode_flag = 0;

        // R5/R4: automatic mode
        mode_auto = 1;
        step(1, 1, 8'hA5, 0, 0, "R5 mismatch");
        step(1, 0, 8'h01, 0, 0, "R5 data discarded");
        step(1, 0, 8'h02, 0, 0, "R5 data discarded");
        step(1, 1, 8'h5A, 0, 0, "R4 match");
        step(1, 0, 8'h03, 0, 0, "R4 data passes");
        // R6: software disable wins over a matching address in the same cycle
        step(1, 1, 8'h5A, 1, 1, "R6 sw vs match");
        step(1, 0, 8'h04, 0, 0, "R6 still off");
        step(1, 1, 8'h5A, 0, 0, "R6 next match re-enables");
        // R7: outside automatic mode addresses leave the state alone
        mode_auto = 0;
        step(1, 1, 8'hEE, 0, 0, "R7 no auto mismatch");
        step(1, 0, 8'h05, 0, 0, "R7 data still passes");
        // R9: no interrupt with flagging mode off
        step(1, 1, 8'h77, 0, 0, "R9 no irq");

        // Constrained random
        for (int blk = 0; blk < 20; blk++) begin
            mode_flag    = 1'($urandom % 2);
            mode_auto    = 1'($urandom % 2);
            station_addr = 8'($urandom);
            for (int i = 0; i < 150; i++) begin
                bit       v   = ($urandom % 4) != 0;
                bit       b9  = ($urandom % 4) == 0;
                bit [7:0] d   = (($urandom % 3) == 0) ? station_addr : 8'($urandom);
                bit       sw  = ($urandom % 32) == 0;
                bit       swv = 1'($urandom % 2);
                step(v, b9, d, sw, swv, "rand");
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule